// File: doc/BRIEF.md
# SDRAM Command Sequencer with Auto-Refresh

This block sits between a simple host request port and the command pins of an SDRAM device. A host presents one access at a time: a bank, a row, a column, a read/write flag and an auto-close flag. The sequencer works out which commands that access needs. A row that is already open is accessed directly. A closed bank is opened first. A bank holding another row is precharged and then reopened. Once the column command can be issued, the access is granted. The sequencer keeps its own record of the open row in each of the four banks, and it inserts NOP cycles wherever a minimum command spacing applies.

After reset the block runs a fixed power-on command sequence and only then accepts host traffic. A free-running interval counter then requests an auto-refresh at a fixed period. That request beats any waiting host access: open banks are closed together and the refresh follows. All spacings are parameters counted in controller clocks. The data bus, the strobes and the electrical start-up conditions belong to other blocks.

Top module: `sdram_cmd_seq`

## Requirements
- R1: Commands are driven registered as {cs_no, ras_no, cas_no, we_no}: 0011 ACTIVE, 0101 READ, 0100 WRITE, 0010 PRECHARGE, 0001 AUTO REFRESH, 0000 LOAD MODE, 0111 NOP. NOP is on the pins during reset and in every cycle without a command, and no other code ever appears.
- R2: After reset the first five commands are, in order: PRECHARGE with addr_o[AP_BIT]=1, AUTO REFRESH, AUTO REFRESH, LOAD MODE with ba_o=1 and addr_o=EMODE_OP, and LOAD MODE with ba_o=0 and addr_o=MODE_OP. req_ready_o stays low until all five have been issued.
- R3: An access to a bank with no open row issues ACTIVE with ba_o equal to the request bank and addr_o equal to the request row. The column command follows no sooner than T_RCD cycles later.
- R4: req_ready_o is high for exactly the cycles in which a column command is decided. That command appears on the pins in the next cycle: READ or WRITE according to req_write_i, with ba_o equal to the request bank, addr_o[COL_W-1:0] equal to the column, and addr_o[AP_BIT] equal to req_autopre_i.
- R5: An access to the row that is already open in its bank issues no ACTIVE and no PRECHARGE before its column command.
- R6: An access to a bank that holds a different row first issues PRECHARGE with addr_o[AP_BIT]=0 and ba_o equal to that bank. ACTIVE follows no sooner than T_RP cycles after any PRECHARGE.
- R7: A column command with the auto-close bit set leaves its bank closed. The next access to that bank issues ACTIVE without a PRECHARGE, no sooner than T_APRE cycles after the column command.
- R8: Refresh requests are raised every T_REFI cycles after the start-up sequence. When one is served, any open bank is first closed with a PRECHARGE that has addr_o[AP_BIT]=1, and AUTO REFRESH is issued only when all banks are closed. With no other traffic, the first refresh PRECHARGE appears T_REFI+1 cycles after the final LOAD MODE. ACTIVE follows AUTO REFRESH by at least T_RFC cycles.
- R9: A pending refresh takes priority over a pending host request. Between the refresh's closing PRECHARGE and its AUTO REFRESH, no ACTIVE and no column command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Host access pending |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bank_i | input | BA_W | Target bank |
| req_row_i | input | ROW_W | Target row |
| req_col_i | input | COL_W | Target column |
| req_autopre_i | input | 1 | Close the row after this access |
| req_ready_o | output | 1 | Grant; the access is taken in this cycle |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ROW_W | Multiplexed row/column/opcode address |

## Verification
The interesting coincidence is a refresh interval expiring while a host access is already waiting and banks are open. The bench provokes it by holding a stream of row-hit reads valid across the interval boundary. It then judges that the stream stops, that the banks close with a precharge-all, and that auto-refresh follows with no activate or column command in between. A pin-level monitor checks spacing from ACTIVE to the next column command, from any PRECHARGE or AUTO REFRESH to the next ACTIVE, and from an auto-closing access to the reopening of its bank. This covers both the host traffic and the refresh traffic that cuts into it.

// File: rtl/sdram_seq_pkg.sv
`timescale 1ns/1ps
package sdram_seq_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } cmd_e;

  localparam int INIT_STEPS = 5;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sdram_bank_table.sv
`timescale 1ns/1ps
module sdram_bank_table #(
  parameter int BA_W  = 2,
  parameter int ROW_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic             close_one_i,
  input  logic             close_all_i,
  input  logic [BA_W-1:0]  sel_bank_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             sel_open_o,
  output logic [ROW_W-1:0] sel_row_o,
  output logic             any_open_o
);
  localparam int BANKS = 1 << BA_W;

  logic [BANKS-1:0] valid_q;
  logic [ROW_W-1:0] row_q [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic hit_sel;
    assign hit_sel = (sel_bank_i == BA_W'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[b] <= 1'b0;
        row_q[b]   <= '0;
      end else if (close_all_i || (close_one_i && hit_sel)) begin
        valid_q[b] <= 1'b0;
      end else if (open_i && hit_sel) begin
        valid_q[b] <= 1'b1;
        row_q[b]   <= row_i;
      end
    end
  end

  assign sel_open_o = valid_q[sel_bank_i];
  assign sel_row_o  = row_q[sel_bank_i];
  assign any_open_o = |valid_q;
endmodule

// File: rtl/sdram_gap_counter.sv
`timescale 1ns/1ps
module sdram_gap_counter #(
  parameter int GAP_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [GAP_W-1:0] wait_i,
  output logic             busy_o
);
  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= wait_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/sdram_refresh_timer.sv
`timescale 1ns/1ps
module sdram_refresh_timer #(
  parameter int T_REFI = 1560
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic ack_i,
  output logic pend_o
);
  localparam int REFI_W = $clog2(T_REFI + 1);

  logic [REFI_W-1:0] cnt_q;
  logic              expire;

  assign expire = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= REFI_W'(T_REFI - 1);
      pend_o <= 1'b0;
    end else begin
      if (run_i) cnt_q <= expire ? REFI_W'(T_REFI - 1) : cnt_q - 1'b1;
      if (expire)     pend_o <= 1'b1;
      else if (ack_i) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_cmd_seq.sv
`timescale 1ns/1ps
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int AP_BIT = 10,
  parameter int T_RP   = 3,
  parameter int T_RFC  = 7,
  parameter int T_RCD  = 2,
  parameter int T_MRD  = 2,
  parameter int T_APRE = 4,
  parameter int T_REFI = 1560,
  parameter logic [ROW_W-1:0] MODE_OP  = 13'h0031,
  parameter logic [ROW_W-1:0] EMODE_OP = 13'h0002
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [BA_W-1:0]  req_bank_i,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic             req_autopre_i,
  output logic             req_ready_o,
  output logic             cs_no,
  output logic             ras_no,
  output logic             cas_no,
  output logic             we_no,
  output logic [BA_W-1:0]  ba_o,
  output logic [ROW_W-1:0] addr_o
);
  localparam int GAP_MAX = max_of(max_of(max_of(T_RP, T_RFC), max_of(T_RCD, T_MRD)), T_APRE);
  localparam int GAP_W   = $clog2(GAP_MAX + 1);
  localparam int STEP_W  = $clog2(INIT_STEPS + 1);

  cmd_e             cmd_d, cmd_q;
  logic [BA_W-1:0]  ba_d, ba_q;
  logic [ROW_W-1:0] addr_d, addr_q;
  logic [STEP_W-1:0] step_q;
  logic             init_done, step_inc;
  logic             gap_busy, gap_load;
  logic [GAP_W-1:0] gap_val;
  logic             ref_pend, ref_ack;
  logic             tb_open, tb_close_one, tb_close_all;
  logic             sel_open, any_open, row_hit;
  logic [ROW_W-1:0] sel_row;
  logic             grant;

  assign init_done = (step_q == STEP_W'(INIT_STEPS));
  assign row_hit   = sel_open && (sel_row == req_row_i);

  sdram_bank_table #(.BA_W(BA_W), .ROW_W(ROW_W)) u_banks (
    .clk_i, .rst_ni,
    .open_i(tb_open), .close_one_i(tb_close_one), .close_all_i(tb_close_all),
    .sel_bank_i(req_bank_i), .row_i(req_row_i),
    .sel_open_o(sel_open), .sel_row_o(sel_row), .any_open_o(any_open)
  );

  sdram_gap_counter #(.GAP_W(GAP_W)) u_gap (
    .clk_i, .rst_ni, .load_i(gap_load), .wait_i(gap_val), .busy_o(gap_busy)
  );

  sdram_refresh_timer #(.T_REFI(T_REFI)) u_refi (
    .clk_i, .rst_ni, .run_i(init_done), .ack_i(ref_ack), .pend_o(ref_pend)
  );

  always_comb begin
    cmd_d        = CMD_NOP;
    ba_d         = '0;
    addr_d       = '0;
    grant        = 1'b0;
    tb_open      = 1'b0;
    tb_close_one = 1'b0;
    tb_close_all = 1'b0;
    ref_ack      = 1'b0;
    gap_load     = 1'b0;
    gap_val      = '0;
    step_inc     = 1'b0;
    if (!gap_busy) begin
      if (!init_done) begin
        step_inc = 1'b1;
        gap_load = 1'b1;
        unique case (step_q)
          STEP_W'(0): begin
            cmd_d = CMD_PRE; addr_d[AP_BIT] = 1'b1; tb_close_all = 1'b1;
            gap_val = GAP_W'(T_RP - 1);
          end
          STEP_W'(1), STEP_W'(2): begin
            cmd_d = CMD_REF; gap_val = GAP_W'(T_RFC - 1);
          end
          STEP_W'(3): begin
            cmd_d = CMD_LMR; ba_d = BA_W'(1); addr_d = EMODE_OP;
            gap_val = GAP_W'(T_MRD - 1);
          end
          default: begin
            cmd_d = CMD_LMR; ba_d = '0; addr_d = MODE_OP;
            gap_val = GAP_W'(T_MRD - 1);
          end
        endcase
      end else if (ref_pend) begin
        gap_load = 1'b1;
        if (any_open) begin
          cmd_d = CMD_PRE; addr_d[AP_BIT] = 1'b1; tb_close_all = 1'b1;
          gap_val = GAP_W'(T_RP - 1);
        end else begin
          cmd_d = CMD_REF; ref_ack = 1'b1;
          gap_val = GAP_W'(T_RFC - 1);
        end
      end else if (req_valid_i) begin
        gap_load = 1'b1;
        ba_d     = req_bank_i;
        if (row_hit) begin
          cmd_d  = req_write_i ? CMD_WR : CMD_RD;
          addr_d = ROW_W'(req_col_i);
          addr_d[AP_BIT] = req_autopre_i;
          grant  = 1'b1;
          tb_close_one = req_autopre_i;
          gap_val = req_autopre_i ? GAP_W'(T_APRE - 1) : '0;
        end else if (sel_open) begin
          cmd_d = CMD_PRE; tb_close_one = 1'b1;
          gap_val = GAP_W'(T_RP - 1);
        end else begin
          cmd_d = CMD_ACT; addr_d = req_row_i; tb_open = 1'b1;
          gap_val = GAP_W'(T_RCD - 1);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      step_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      ba_q   <= ba_d;
      addr_q <= addr_d;
      if (step_inc) step_q <= step_q + 1'b1;
    end
  end

  assign req_ready_o = grant;
  assign {cs_no, ras_no, cas_no, we_no} = cmd_q;
  assign ba_o   = ba_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/sdram_cmd_seq_chk.sv
`timescale 1ns/1ps
module sdram_cmd_seq_chk
  import sdram_seq_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ROW_W  = 13,
  parameter int AP_BIT = 10,
  parameter int T_RP   = 3,
  parameter int T_RFC  = 7,
  parameter int T_RCD  = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_ready_o,
  input logic             cs_no,
  input logic             ras_no,
  input logic             cas_no,
  input logic             we_no,
  input logic [BA_W-1:0]  ba_o,
  input logic [ROW_W-1:0] addr_o
);
  localparam int BANKS = 1 << BA_W;

  logic [3:0]       pin;
  logic             is_act, is_pre, is_ref, is_lmr, is_col;
  logic [15:0]      since_pre, since_ref, since_act;
  logic [BANKS-1:0] open_map;
  logic [1:0]       lmr_seen;

  assign pin    = {cs_no, ras_no, cas_no, we_no};
  assign is_act = (pin == CMD_ACT);
  assign is_pre = (pin == CMD_PRE);
  assign is_ref = (pin == CMD_REF);
  assign is_lmr = (pin == CMD_LMR);
  assign is_col = (pin == CMD_RD) || (pin == CMD_WR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_pre <= '1; since_ref <= '1; since_act <= '1;
      open_map  <= '0; lmr_seen  <= '0;
    end else begin
      since_pre <= is_pre ? 16'd1 : (since_pre == '1 ? since_pre : since_pre + 16'd1);
      since_ref <= is_ref ? 16'd1 : (since_ref == '1 ? since_ref : since_ref + 16'd1);
      since_act <= is_act ? 16'd1 : (since_act == '1 ? since_act : since_act + 16'd1);
      if (is_lmr && lmr_seen != 2'd3) lmr_seen <= lmr_seen + 2'd1;
      if (is_act) open_map[ba_o] <= 1'b1;
      else if (is_pre && addr_o[AP_BIT]) open_map <= '0;
      else if ((is_pre || is_col) && addr_o[AP_BIT] == is_col) open_map[ba_o] <= 1'b0;
    end
  end

  // R1
  legal_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin inside {CMD_LMR, CMD_REF, CMD_PRE, CMD_ACT, CMD_WR, CMD_RD, CMD_NOP});
  // R2
  no_early_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> lmr_seen >= 2'd2);
  // R4
  grant_column_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |=> is_col);
  // R3
  act_to_col_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col |-> since_act >= 16'(T_RCD));
  // R3
  act_bank_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |-> !open_map[ba_o]);
  // R5
  col_bank_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col |-> open_map[ba_o]);
  // R6
  pre_to_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |-> since_pre >= 16'(T_RP));
  // R8
  ref_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ref |-> open_map == '0);
  // R8
  ref_to_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |-> since_ref >= 16'(T_RFC));
endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(
  .BA_W(BA_W), .ROW_W(ROW_W), .AP_BIT(AP_BIT),
  .T_RP(T_RP), .T_RFC(T_RFC), .T_RCD(T_RCD)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_ready_o(req_ready_o),
  .cs_no(cs_no), .ras_no(ras_no), .cas_no(cas_no), .we_no(we_no),
  .ba_o(ba_o), .addr_o(addr_o)
);

// File: tb/sdram_cmd_seq_bench.sv
`timescale 1ns/100ps
module sdram_cmd_seq_bench;
  localparam int BA_W = 2, ROW_W = 13, COL_W = 10, AP_BIT = 10;
  localparam int T_RP = 3, T_RFC = 7, T_RCD = 2, T_MRD = 2, T_APRE = 4, T_REFI = 300;
  localparam logic [12:0] MODE_OP = 13'h0031, EMODE_OP = 13'h0002;
  localparam logic [3:0] C_LMR = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                         C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101, C_NOP = 4'b0111;

  typedef struct packed {
    logic        wr;
    logic [1:0]  bank;
    logic [12:0] row;
    logic [9:0]  col;
    logic        ap;
    logic        epre;
    logic        eact;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 13'h0100, 10'h010, 1'b0, 1'b0, 1'b1},  // closed bank
    '{1'b1, 2'd0, 13'h0100, 10'h020, 1'b0, 1'b0, 1'b0},  // hit
    '{1'b0, 2'd0, 13'h0155, 10'h3FF, 1'b0, 1'b1, 1'b1},  // miss
    '{1'b1, 2'd1, 13'h1FFF, 10'h000, 1'b1, 1'b0, 1'b1},  // closed, auto-close
    '{1'b0, 2'd1, 13'h1FFF, 10'h005, 1'b0, 1'b0, 1'b1},  // reopen after auto-close
    '{1'b1, 2'd2, 13'h0000, 10'h2AA, 1'b0, 1'b0, 1'b1},
    '{1'b0, 2'd2, 13'h0000, 10'h155, 1'b1, 1'b0, 1'b0},  // hit, auto-close
    '{1'b0, 2'd3, 13'h0AAA, 10'h001, 1'b0, 1'b0, 1'b1},
    '{1'b0, 2'd0, 13'h0155, 10'h3FF, 1'b0, 1'b0, 1'b0},  // hit, other banks touched
    '{1'b1, 2'd1, 13'h0001, 10'h003, 1'b0, 1'b1, 1'b1}   // miss
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_write_i = 1'b0, req_autopre_i = 1'b0;
  logic [BA_W-1:0] req_bank_i = '0;
  logic [ROW_W-1:0] req_row_i = '0;
  logic [COL_W-1:0] req_col_i = '0;
  logic req_ready_o, cs_no, ras_no, cas_no, we_no;
  logic [BA_W-1:0] ba_o;
  logic [ROW_W-1:0] addr_o;

  always #2 clk_i = ~clk_i;

  sdram_cmd_seq #(
    .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .AP_BIT(AP_BIT),
    .T_RP(T_RP), .T_RFC(T_RFC), .T_RCD(T_RCD), .T_MRD(T_MRD), .T_APRE(T_APRE),
    .T_REFI(T_REFI), .MODE_OP(MODE_OP), .EMODE_OP(EMODE_OP)
  ) u_sdram_cmd_seq (.*);

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // pin monitor
  int cyc = 0;
  always @(posedge clk_i) cyc++;

  int cnt_pre1 = 0, cnt_preall = 0, cnt_act = 0, cnt_ref = 0, cnt_lmr = 0, cnt_col = 0;
  int t_pre = -1000, t_ref = -1000, t_act = -1000, t_mrs = 0, t_preall = 0;
  int t_ap [4] = '{default: -1000};
  bit ap_pending [4] = '{default: 1'b0};
  logic [3:0] open_m = '0;
  logic [12:0] last_act_row;
  logic [1:0] last_col_ba;
  logic [12:0] last_col_addr;
  logic last_col_wr;
  bit early_grant = 1'b0;
  logic [3:0] log_cmd [8];
  logic [1:0] log_ba [8];
  logic [12:0] log_addr [8];
  int nlog = 0;

  always @(negedge clk_i) if (rst_ni) begin
    logic [3:0] c;
    c = {cs_no, ras_no, cas_no, we_no};
    if (req_ready_o && cnt_lmr < 2) early_grant = 1'b1;
    if (c != C_NOP && nlog < 8) begin
      log_cmd[nlog] = c; log_ba[nlog] = ba_o; log_addr[nlog] = addr_o; nlog++;
    end
    case (c)
      C_NOP: ;
      C_PRE: begin
        t_pre = cyc;
        if (addr_o[AP_BIT]) begin cnt_preall++; t_preall = cyc; open_m = '0; end
        else begin cnt_pre1++; open_m[ba_o] = 1'b0; end
      end
      C_ACT: begin
        chk(cyc - t_pre >= T_RP, "R6", "PRE->ACT gap", cyc - t_pre, T_RP);
        chk(cyc - t_ref >= T_RFC, "R8", "REF->ACT gap", cyc - t_ref, T_RFC);
        if (ap_pending[ba_o]) begin
          chk(cyc - t_ap[ba_o] >= T_APRE, "R7", "auto-close->ACT gap", cyc - t_ap[ba_o], T_APRE);
          ap_pending[ba_o] = 1'b0;
        end
        cnt_act++; t_act = cyc; last_act_row = addr_o; open_m[ba_o] = 1'b1;
      end
      C_REF: begin
        chk(open_m == 4'h0, "R8", "banks open at REF", open_m, 0);
        cnt_ref++; t_ref = cyc;
      end
      C_LMR: begin
        cnt_lmr++;
        if (cnt_lmr == 2) t_mrs = cyc;
      end
      C_RD, C_WR: begin
        chk(cyc - t_act >= T_RCD, "R3", "ACT->column gap", cyc - t_act, T_RCD);
        chk(open_m[ba_o], "R5", "column to closed bank", 0, 1);
        cnt_col++; last_col_ba = ba_o; last_col_addr = addr_o; last_col_wr = (c == C_WR);
        if (addr_o[AP_BIT]) begin
          ap_pending[ba_o] = 1'b1; t_ap[ba_o] = cyc; open_m[ba_o] = 1'b0;
        end
      end
      default: chk(1'b0, "R1", "illegal command code", c, C_NOP);
    endcase
  end

  task automatic run_vec(input vec_t v, input int idx);
    int p0, a0, c0, n;
    bit got;
    @(negedge clk_i); #0.5;
    p0 = cnt_pre1; a0 = cnt_act; c0 = cnt_col;
    req_write_i = v.wr; req_bank_i = v.bank; req_row_i = v.row;
    req_col_i = v.col; req_autopre_i = v.ap; req_valid_i = 1'b1;
    got = 1'b0; n = 0;
    while (!got && n < 300) begin
      #0.5;
      if (req_ready_o) got = 1'b1;
      @(negedge clk_i); #0.5;
      n++;
    end
    req_valid_i = 1'b0;
    chk(got, "R4", $sformatf("vector %0d granted", idx), got, 1);
    chk(cnt_col - c0 == 1, "R4", "one column command", cnt_col - c0, 1);
    chk(last_col_wr == v.wr, "R4", "read/write code", last_col_wr, v.wr);
    chk(last_col_ba == v.bank, "R4", "column bank", last_col_ba, v.bank);
    chk(last_col_addr[COL_W-1:0] == v.col, "R4", "column address", last_col_addr[COL_W-1:0], v.col);
    chk(last_col_addr[AP_BIT] == v.ap, "R7", "auto-close bit", last_col_addr[AP_BIT], v.ap);
    chk(cnt_pre1 - p0 == int'(v.epre), "R6", "single-bank PRE count", cnt_pre1 - p0, v.epre);
    chk(cnt_act - a0 == int'(v.eact), v.eact ? "R3" : "R5", "ACT count", cnt_act - a0, v.eact);
    if (v.eact) chk(last_act_row == v.row, "R3", "ACT row", last_act_row, v.row);
  endtask

  initial begin
    int n, pa0, r0, c0, a0;
    repeat (3) @(negedge clk_i);
    // reset state
    chk({cs_no, ras_no, cas_no, we_no} == C_NOP, "R1", "pins in reset", {cs_no, ras_no, cas_no, we_no}, C_NOP);
    chk(!req_ready_o, "R2", "grant in reset", req_ready_o, 0);
    @(negedge clk_i); #0.5; rst_ni = 1'b1;

    // vector 0 is held valid through start-up
    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    chk(!early_grant, "R2", "grant before start-up done", early_grant, 0);
    chk(log_cmd[0] == C_PRE && log_addr[0][AP_BIT], "R2", "step 0 PRE-all", {log_cmd[0], log_addr[0]}, {C_PRE, 13'h0400});
    chk(log_cmd[1] == C_REF, "R2", "step 1 REF", log_cmd[1], C_REF);
    chk(log_cmd[2] == C_REF, "R2", "step 2 REF", log_cmd[2], C_REF);
    chk(log_cmd[3] == C_LMR && log_ba[3] == 2'd1 && log_addr[3] == EMODE_OP, "R2", "step 3 ext mode",
        {log_cmd[3], log_ba[3], log_addr[3]}, {C_LMR, 2'd1, EMODE_OP});
    chk(log_cmd[4] == C_LMR && log_ba[4] == 2'd0 && log_addr[4] == MODE_OP, "R2", "step 4 mode",
        {log_cmd[4], log_ba[4], log_addr[4]}, {C_LMR, 2'd0, MODE_OP});

    // idle NOP, then first refresh with banks open
    @(negedge clk_i); #0.5;
    chk({cs_no, ras_no, cas_no, we_no} == C_NOP, "R1", "idle pins", {cs_no, ras_no, cas_no, we_no}, C_NOP);
    n = 0;
    while (cnt_ref < 3 && n < 2 * T_REFI) begin @(negedge clk_i); #0.5; n++; end
    chk(cnt_ref == 3, "R8", "refresh issued", cnt_ref, 3);
    chk(cnt_preall == 2, "R8", "PRE-all before refresh", cnt_preall, 2);
    chk(t_preall - t_mrs == T_REFI + 1, "R8", "refresh interval", t_preall - t_mrs, T_REFI + 1);

    // refresh expiring under a held request stream
    @(negedge clk_i); #0.5;
    pa0 = cnt_preall;
    req_write_i = 1'b0; req_bank_i = 2'd0; req_row_i = 13'h00AA; req_col_i = 10'h007;
    req_autopre_i = 1'b0; req_valid_i = 1'b1;
    n = 0;
    while (cnt_preall == pa0 && n < 3 * T_REFI) begin @(negedge clk_i); #0.5; n++; end
    chk(cnt_preall == pa0 + 1, "R9", "PRE-all under load", cnt_preall - pa0, 1);
    chk(cnt_col > 10, "R9", "stream served before refresh", cnt_col, 11);
    c0 = cnt_col; a0 = cnt_act; r0 = cnt_ref;
    n = 0;
    while (cnt_ref == r0 && n < 50) begin @(negedge clk_i); #0.5; n++; end
    chk(cnt_ref == r0 + 1, "R9", "REF after PRE-all", cnt_ref - r0, 1);
    chk(cnt_col == c0, "R9", "column between PRE-all and REF", cnt_col - c0, 0);
    chk(cnt_act == a0, "R9", "ACT between PRE-all and REF", cnt_act - a0, 0);
    n = 0;
    while (cnt_col == c0 && n < 50) begin @(negedge clk_i); #0.5; n++; end
    req_valid_i = 1'b0;
    chk(cnt_col == c0 + 1, "R8", "access resumes after refresh", cnt_col - c0, 1);
    chk(cnt_act == a0 + 1, "R3", "row reopened after refresh", cnt_act - a0, 1);

    repeat (5) @(negedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule